// File: doc/BRIEF.md
# Clock Root Staged Configuration Controller

This block is the register-mapped control point of one clock root. Software programs a pre-divider, a source selection, an operating mode and three fractional counter values into staging registers. None of these settings reach the clock path until software asks for it. Software asks by writing the request bit of the command word. The block then moves every staged field into the live settings at once. It clears the request bit by itself, so software can poll that bit to learn when the new settings are in force.

The live settings drive the divider and the counter logic through dedicated output ports. The source selection is offered both as a 3-bit code and as a one-hot vector for an eight-input multiplexer. The command word carries four per-field "changed since the last transfer" flags, a root enable bit, and a status bit that reads 1 while the root is stopped. An external request input can keep the root running even when software has not enabled it.

Top module: `clkroot_ctrl`

## Requirements
- R1: After reset, every staged and live field is zero, the one-hot source vector is 8'h01, the root enable is 0, and the command word reads 32'h8000_0000 while force_on_i is low.
- R2: Word address 0 is the command word. Bit 0 is the transfer request: writing 1 requests a transfer and writing 0 has no effect on it. Bit 1 is the root enable, readable and writable. Bits 4, 5, 6 and 7 are the read-only changed flags for configuration, N, M and D. Bit 31 is the read-only root-off status. All other bits read 0.
- R3: Word address 1 is the configuration word, with the pre-divider in bits PDIV_W-1:0, the source code in bits 10:8 and the mode in bits 13:12. Addresses 3, 2 and 4 hold N, M and D in bits MND_W-1:0. Reads return the staged values, and all other bits read 0.
- R4: A staging write leaves every live output unchanged until a transfer copies it.
- R5: For a request written at clock edge k, all live outputs take the staged values at edge k+1. The request bit reads 1 after edges k and k+1 and reads 0 after edge k+2.
- R6: A write to the configuration, N, M or D word sets its changed flag. Edge k+1 clears every flag, except a flag whose word is written in that same cycle. That flag stays set, and its new value is not copied.
- R7: A staging write after edge k+1 of a pending transfer sets its flag and does not reach the live outputs. A request written while a transfer is pending is dropped.
- R8: root_off_o and command bit 31 read 1 exactly when the root enable is 0 and force_on_i is 0. root_en_o follows a written bit 1 after the write edge.
- R9: src_onehot_o has exactly the bit of index src_sel_o set. mnd_active_o is 1 exactly when the live mode equals 2 (dual-edge).
- R10: Addresses 5 to 7 read 0, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register and sequencer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| force_on_i | input | 1 | External request that holds the root running |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Word address for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pre_div_o | output | PDIV_W | Live pre-divider value |
| src_sel_o | output | 3 | Live source code |
| src_onehot_o | output | 8 | Live source as a one-hot mux select |
| mode_o | output | 2 | Live mode |
| mnd_active_o | output | 1 | Live mode is dual-edge |
| m_o | output | MND_W | Live M value |
| n_o | output | MND_W | Live N value |
| d_o | output | MND_W | Live D value |
| root_en_o | output | 1 | Software root enable |
| root_off_o | output | 1 | Root is stopped |

## Verification
The two functions that can fall in the same cycle are the staged-to-live copy and a software write to a staging word. The bench writes a new configuration word in the cycle right after the request, which is the copy cycle. It then checks three things: the live outputs carry the older value, the read-back shows the newer one, and the configuration changed flag is still set once the request bit has cleared. A second transfer must then deliver the newer value. A request written during the settle cycle must neither stretch the busy window nor start another copy.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 32;
    localparam int SRC_W   = 3;
    localparam int NUM_SRC = 1 << SRC_W;
    localparam int NFLAG   = 4;

    // word addresses
    localparam logic [ADDR_W-1:0] A_CMD = 3'd0;
    localparam logic [ADDR_W-1:0] A_CFG = 3'd1;
    localparam logic [ADDR_W-1:0] A_M   = 3'd2;
    localparam logic [ADDR_W-1:0] A_N   = 3'd3;
    localparam logic [ADDR_W-1:0] A_D   = 3'd4;

    // command word bit positions
    localparam int CMD_REQ_B   = 0;
    localparam int CMD_EN_B    = 1;
    localparam int CMD_FLAG_LO = 4;
    localparam int CMD_OFF_B   = 31;

    // configuration word field positions
    localparam int CFG_SRC_LO  = 8;
    localparam int CFG_MODE_LO = 12;
    localparam logic [1:0] MODE_DUAL = 2'd2;

    // changed-flag index, in command-bit order
    localparam int FL_CFG = 0;
    localparam int FL_N   = 1;
    localparam int FL_M   = 2;
    localparam int FL_D   = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ARMED  = 2'd1,
        SEQ_SETTLE = 2'd2
    } seq_e;
endpackage

// File: rtl/clkroot_seq.sv
module clkroot_seq
    import clkroot_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              req_bit_i,
    input  logic              en_bit_i,
    output logic              busy_o,
    output logic              copy_o,
    output logic              root_en_o
);
    typedef struct packed {
        seq_e st;
        logic en;
    } seq_t;

    seq_t s_d, s_q;
    logic cmd_wr;

    always_comb begin
        s_d    = s_q;
        cmd_wr = wr_en_i && (addr_i == A_CMD);
        if (cmd_wr) begin
            s_d.en = en_bit_i;
        end
        unique case (s_q.st)
            SEQ_IDLE:   if (cmd_wr && req_bit_i) s_d.st = SEQ_ARMED;
            SEQ_ARMED:  s_d.st = SEQ_SETTLE;
            SEQ_SETTLE: s_d.st = SEQ_IDLE;
            default:    s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{st: SEQ_IDLE, en: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o    = (s_q.st != SEQ_IDLE);
    assign copy_o    = (s_q.st == SEQ_ARMED);
    assign root_en_o = s_q.en;
endmodule

// File: rtl/clkroot_shadow.sv
module clkroot_shadow
    import clkroot_pkg::*;
#(
    parameter int PDIV_W = 5,
    parameter int MND_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [PDIV_W-1:0] wr_pdiv_i,
    input  logic [SRC_W-1:0]  wr_src_i,
    input  logic [1:0]        wr_mode_i,
    input  logic [MND_W-1:0]  wr_mnd_i,
    input  logic              copy_i,
    output logic [PDIV_W-1:0] pdiv_o,
    output logic [SRC_W-1:0]  src_o,
    output logic [1:0]        mode_o,
    output logic [MND_W-1:0]  m_o,
    output logic [MND_W-1:0]  n_o,
    output logic [MND_W-1:0]  d_o,
    output logic [NFLAG-1:0]  flags_o
);
    typedef struct packed {
        logic [PDIV_W-1:0] pdiv;
        logic [SRC_W-1:0]  src;
        logic [1:0]        mode;
        logic [MND_W-1:0]  m;
        logic [MND_W-1:0]  n;
        logic [MND_W-1:0]  d;
        logic [NFLAG-1:0]  flags;
    } shd_t;

    shd_t r_d, r_q;
    logic [NFLAG-1:0] hit;

    always_comb begin
        r_d = r_q;
        hit = '0;
        if (wr_en_i) begin
            unique case (addr_i)
                A_CFG: begin
                    r_d.pdiv    = wr_pdiv_i;
                    r_d.src     = wr_src_i;
                    r_d.mode    = wr_mode_i;
                    hit[FL_CFG] = 1'b1;
                end
                A_N: begin
                    r_d.n     = wr_mnd_i;
                    hit[FL_N] = 1'b1;
                end
                A_M: begin
                    r_d.m     = wr_mnd_i;
                    hit[FL_M] = 1'b1;
                end
                A_D: begin
                    r_d.d     = wr_mnd_i;
                    hit[FL_D] = 1'b1;
                end
                default: ;
            endcase
        end
        // the copy edge clears flags, except those written in that same cycle
        if (copy_i) begin
            r_d.flags = hit;
        end else begin
            r_d.flags = r_q.flags | hit;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pdiv_o  = r_q.pdiv;
    assign src_o   = r_q.src;
    assign mode_o  = r_q.mode;
    assign m_o     = r_q.m;
    assign n_o     = r_q.n;
    assign d_o     = r_q.d;
    assign flags_o = r_q.flags;
endmodule

// File: rtl/clkroot_active.sv
module clkroot_active
    import clkroot_pkg::*;
#(
    parameter int PDIV_W = 5,
    parameter int MND_W  = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               copy_i,
    input  logic [PDIV_W-1:0]  sh_pdiv_i,
    input  logic [SRC_W-1:0]   sh_src_i,
    input  logic [1:0]         sh_mode_i,
    input  logic [MND_W-1:0]   sh_m_i,
    input  logic [MND_W-1:0]   sh_n_i,
    input  logic [MND_W-1:0]   sh_d_i,
    output logic [PDIV_W-1:0]  pdiv_o,
    output logic [SRC_W-1:0]   src_o,
    output logic [NUM_SRC-1:0] onehot_o,
    output logic [1:0]         mode_o,
    output logic               dual_o,
    output logic [MND_W-1:0]   m_o,
    output logic [MND_W-1:0]   n_o,
    output logic [MND_W-1:0]   d_o
);
    typedef struct packed {
        logic [PDIV_W-1:0] pdiv;
        logic [SRC_W-1:0]  src;
        logic [1:0]        mode;
        logic [MND_W-1:0]  m;
        logic [MND_W-1:0]  n;
        logic [MND_W-1:0]  d;
    } act_t;

    act_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (copy_i) begin
            a_d.pdiv = sh_pdiv_i;
            a_d.src  = sh_src_i;
            a_d.mode = sh_mode_i;
            a_d.m    = sh_m_i;
            a_d.n    = sh_n_i;
            a_d.d    = sh_d_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sel
        assign onehot_o[g] = (a_q.src == SRC_W'(g));
    end

    assign pdiv_o = a_q.pdiv;
    assign src_o  = a_q.src;
    assign mode_o = a_q.mode;
    assign dual_o = (a_q.mode == MODE_DUAL);
    assign m_o    = a_q.m;
    assign n_o    = a_q.n;
    assign d_o    = a_q.d;
endmodule

// File: rtl/clkroot_rdmux.sv
module clkroot_rdmux
    import clkroot_pkg::*;
#(
    parameter int PDIV_W = 5,
    parameter int MND_W  = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              busy_i,
    input  logic              root_en_i,
    input  logic              root_off_i,
    input  logic [NFLAG-1:0]  flags_i,
    input  logic [PDIV_W-1:0] pdiv_i,
    input  logic [SRC_W-1:0]  src_i,
    input  logic [1:0]        mode_i,
    input  logic [MND_W-1:0]  m_i,
    input  logic [MND_W-1:0]  n_i,
    input  logic [MND_W-1:0]  d_i,
    output logic [DATA_W-1:0] rdata_o
);
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_CMD: begin
                rdata_o[CMD_REQ_B]                 = busy_i;
                rdata_o[CMD_EN_B]                  = root_en_i;
                rdata_o[CMD_FLAG_LO +: NFLAG]      = flags_i;
                rdata_o[CMD_OFF_B]                 = root_off_i;
            end
            A_CFG: begin
                rdata_o[PDIV_W-1:0]                = pdiv_i;
                rdata_o[CFG_SRC_LO +: SRC_W]       = src_i;
                rdata_o[CFG_MODE_LO +: 2]          = mode_i;
            end
            A_M:     rdata_o[MND_W-1:0] = m_i;
            A_N:     rdata_o[MND_W-1:0] = n_i;
            A_D:     rdata_o[MND_W-1:0] = d_i;
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/clkroot_ctrl.sv
// PDIV_W must stay at or below CFG_SRC_LO (8) so the fields do not overlap.
module clkroot_ctrl
    import clkroot_pkg::*;
#(
    parameter int PDIV_W = 5,
    parameter int MND_W  = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                force_on_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [PDIV_W-1:0]   pre_div_o,
    output logic [SRC_W-1:0]    src_sel_o,
    output logic [NUM_SRC-1:0]  src_onehot_o,
    output logic [1:0]          mode_o,
    output logic                mnd_active_o,
    output logic [MND_W-1:0]    m_o,
    output logic [MND_W-1:0]    n_o,
    output logic [MND_W-1:0]    d_o,
    output logic                root_en_o,
    output logic                root_off_o
);
    logic              busy, copy_p, root_en;
    logic [NFLAG-1:0]  flags;
    logic [PDIV_W-1:0] sh_pdiv;
    logic [SRC_W-1:0]  sh_src;
    logic [1:0]        sh_mode;
    logic [MND_W-1:0]  sh_m, sh_n, sh_d;

    clkroot_seq u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .req_bit_i (wdata_i[CMD_REQ_B]),
        .en_bit_i  (wdata_i[CMD_EN_B]),
        .busy_o    (busy),
        .copy_o    (copy_p),
        .root_en_o (root_en)
    );

    clkroot_shadow #(.PDIV_W(PDIV_W), .MND_W(MND_W)) u_shadow (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wr_pdiv_i (wdata_i[PDIV_W-1:0]),
        .wr_src_i  (wdata_i[CFG_SRC_LO +: SRC_W]),
        .wr_mode_i (wdata_i[CFG_MODE_LO +: 2]),
        .wr_mnd_i  (wdata_i[MND_W-1:0]),
        .copy_i    (copy_p),
        .pdiv_o    (sh_pdiv),
        .src_o     (sh_src),
        .mode_o    (sh_mode),
        .m_o       (sh_m),
        .n_o       (sh_n),
        .d_o       (sh_d),
        .flags_o   (flags)
    );

    clkroot_active #(.PDIV_W(PDIV_W), .MND_W(MND_W)) u_active (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .copy_i    (copy_p),
        .sh_pdiv_i (sh_pdiv),
        .sh_src_i  (sh_src),
        .sh_mode_i (sh_mode),
        .sh_m_i    (sh_m),
        .sh_n_i    (sh_n),
        .sh_d_i    (sh_d),
        .pdiv_o    (pre_div_o),
        .src_o     (src_sel_o),
        .onehot_o  (src_onehot_o),
        .mode_o    (mode_o),
        .dual_o    (mnd_active_o),
        .m_o       (m_o),
        .n_o       (n_o),
        .d_o       (d_o)
    );

    assign root_en_o  = root_en;
    assign root_off_o = !(root_en || force_on_i);

    clkroot_rdmux #(.PDIV_W(PDIV_W), .MND_W(MND_W)) u_rdmux (
        .addr_i     (addr_i),
        .busy_i     (busy),
        .root_en_i  (root_en),
        .root_off_i (root_off_o),
        .flags_i    (flags),
        .pdiv_i     (sh_pdiv),
        .src_i      (sh_src),
        .mode_i     (sh_mode),
        .m_i        (sh_m),
        .n_i        (sh_n),
        .d_i        (sh_d),
        .rdata_o    (rdata_o)
    );
endmodule

// File: rtl/clkroot_ctrl_chk.sv
module clkroot_ctrl_chk
    import clkroot_pkg::*;
#(
    parameter int PDIV_W = 5,
    parameter int MND_W  = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               copy_p,
    input logic               busy,
    input logic               force_on_i,
    input logic               root_off_o,
    input logic [NFLAG-1:0]   flags,
    input logic [PDIV_W-1:0]  sh_pdiv,
    input logic [SRC_W-1:0]   sh_src,
    input logic [1:0]         sh_mode,
    input logic [MND_W-1:0]   sh_m,
    input logic [MND_W-1:0]   sh_n,
    input logic [MND_W-1:0]   sh_d,
    input logic [PDIV_W-1:0]  pre_div_o,
    input logic [SRC_W-1:0]   src_sel_o,
    input logic [NUM_SRC-1:0] src_onehot_o,
    input logic [1:0]         mode_o,
    input logic [MND_W-1:0]   m_o,
    input logic [MND_W-1:0]   n_o,
    input logic [MND_W-1:0]   d_o
);
    // R5
    copy_to_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        copy_p |=> (src_sel_o == $past(sh_src)) && (pre_div_o == $past(sh_pdiv))
                   && (mode_o == $past(sh_mode)) && (m_o == $past(sh_m))
                   && (n_o == $past(sh_n)) && (d_o == $past(sh_d)));

    // R4
    live_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !copy_p |=> $stable(src_sel_o) && $stable(pre_div_o) && $stable(mode_o)
                    && $stable(m_o) && $stable(n_o) && $stable(d_o));

    // R5
    busy_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        copy_p |=> (busy && !copy_p) ##1 !busy);

    // R6
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !copy_p |=> ((~flags & $past(flags)) == '0));

    // R8
    force_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        force_on_i |-> !root_off_o);

    // R9
    onehot_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(src_onehot_o) == 1) && src_onehot_o[src_sel_o]);
endmodule

bind clkroot_ctrl clkroot_ctrl_chk #(.PDIV_W(PDIV_W), .MND_W(MND_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .copy_p       (copy_p),
    .busy         (busy),
    .force_on_i   (force_on_i),
    .root_off_o   (root_off_o),
    .flags        (flags),
    .sh_pdiv      (sh_pdiv),
    .sh_src       (sh_src),
    .sh_mode      (sh_mode),
    .sh_m         (sh_m),
    .sh_n         (sh_n),
    .sh_d         (sh_d),
    .pre_div_o    (pre_div_o),
    .src_sel_o    (src_sel_o),
    .src_onehot_o (src_onehot_o),
    .mode_o       (mode_o),
    .m_o          (m_o),
    .n_o          (n_o),
    .d_o          (d_o)
);

// File: tb/clkroot_ctrl_tb.sv
module clkroot_ctrl_tb;
    localparam int CLK_P = 10;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        force_on_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [4:0]  pre_div_o;
    logic [2:0]  src_sel_o;
    logic [7:0]  src_onehot_o;
    logic [1:0]  mode_o;
    logic        mnd_active_o;
    logic [7:0]  m_o, n_o, d_o;
    logic        root_en_o, root_off_o;

    int n_chk = 0;
    int n_bad = 0;

    clkroot_ctrl u_dut (.*);

    always #(CLK_P/2) clk_i = ~clk_i;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en_i = 1'b1;
        addr_i  = a;
        wdata_i = d;
        @(negedge clk_i);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(3'd0, v); check("R1 cmd", v, 32'h8000_0000);
        rd(3'd1, v); check("R1 cfg", v, 32'h0);
        rd(3'd3, v); check("R1 n", v, 32'h0);
        check("R1 onehot", {24'h0, src_onehot_o}, 32'h01);
        check("R1 root_off", {31'h0, root_off_o}, 32'h1);
    endtask

    task automatic t_stage;
        logic [31:0] v;
        wr(3'd1, 32'hFFF0_25F3);
        rd(3'd1, v); check("R3 cfg fields", v, 32'h0000_2513);
        rd(3'd0, v); check("R6 cfg flag", v, 32'h8000_0010);
        check("R4 src held", {29'h0, src_sel_o}, 32'h0);
        check("R4 mode held", {30'h0, mode_o}, 32'h0);
        wr(3'd2, 32'h0000_003C);
        wr(3'd3, 32'hFFFF_FFA5);
        wr(3'd4, 32'h0000_005A);
        rd(3'd3, v); check("R3 n field", v, 32'h0000_00A5);
        rd(3'd0, v); check("R2 R6 all flags", v, 32'h8000_00F0);
        check("R4 m held", {24'h0, m_o}, 32'h0);
    endtask

    task automatic t_update;
        logic [31:0] v;
        wr(3'd0, 32'h0000_0001);
        rd(3'd0, v); check("R5 req after k", v, 32'h8000_00F1);
        check("R5 src before copy", {29'h0, src_sel_o}, 32'h0);
        @(negedge clk_i);
        check("R5 src", {29'h0, src_sel_o}, 32'h5);
        check("R5 pdiv", {27'h0, pre_div_o}, 32'h13);
        check("R5 mnd", {8'h0, m_o, n_o, d_o}, 32'h003C_A55A);
        check("R9 dual", {30'h0, mode_o}, 32'h2);
        check("R9 mnd_active", {31'h0, mnd_active_o}, 32'h1);
        check("R9 onehot", {24'h0, src_onehot_o}, 32'h20);
        rd(3'd0, v); check("R5 R6 after k+1", v, 32'h8000_0001);
        @(negedge clk_i);
        rd(3'd0, v); check("R5 after k+2", v, 32'h8000_0000);
    endtask

    task automatic t_root;
        logic [31:0] v;
        wr(3'd0, 32'h0000_0002);
        check("R8 en", {30'h0, root_en_o, root_off_o}, 32'h2);
        rd(3'd0, v); check("R2 R8 cmd en", v, 32'h0000_0002);
        wr(3'd0, 32'h0000_0000);
        check("R8 disabled", {30'h0, root_en_o, root_off_o}, 32'h1);
        force_on_i = 1'b1;
        rd(3'd0, v); check("R8 forced", v, 32'h0);
        check("R8 forced pin", {31'h0, root_off_o}, 32'h0);
        force_on_i = 1'b0;
        #1 check("R8 release", {31'h0, root_off_o}, 32'h1);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        wr(3'd1, 32'h0000_0301);
        wr(3'd0, 32'h0000_0001);
        wr(3'd1, 32'h0000_0702);   // lands on the copy edge
        check("R6 old src copied", {29'h0, src_sel_o}, 32'h3);
        check("R6 old pdiv copied", {27'h0, pre_div_o}, 32'h1);
        check("R9 not dual", {31'h0, mnd_active_o}, 32'h0);
        rd(3'd0, v); check("R6 flag kept", v, 32'h8000_0011);
        @(negedge clk_i);
        rd(3'd0, v); check("R6 flag after done", v, 32'h8000_0010);
        rd(3'd1, v); check("R3 staged new", v, 32'h0000_0702);
        wr(3'd0, 32'h0000_0001);
        @(negedge clk_i);
        check("R5 second copy", {29'h0, src_sel_o}, 32'h7);
    endtask

    task automatic t_pending;
        logic [31:0] v;
        @(negedge clk_i);
        wr(3'd0, 32'h0000_0001);
        @(negedge clk_i);
        wr(3'd2, 32'h0000_0011);   // settle cycle
        rd(3'd0, v); check("R7 flag set late", v, 32'h8000_0040);
        check("R7 m not copied", {24'h0, m_o}, 32'h3C);
        wr(3'd0, 32'h0000_0001);
        @(negedge clk_i);
        check("R5 m copied", {24'h0, m_o}, 32'h11);
        wr(3'd0, 32'h0000_0001);   // request in settle cycle
        rd(3'd0, v); check("R7 req dropped", v, 32'h8000_0000);
        wr(3'd2, 32'h0000_0022);
        @(negedge clk_i);
        check("R7 no extra copy", {24'h0, m_o}, 32'h11);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), v); check("R10 read zero", v, 32'h0);
        end
        rd(3'd0, v); check("R10 cmd untouched", v, 32'h8000_0040);
        rd(3'd1, v); check("R10 cfg untouched", v, 32'h0000_0702);
        check("R10 live untouched", {24'h0, src_onehot_o}, 32'h80);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_stage();
        t_update();
        t_root();
        t_collide();
        t_pending();
        t_unmapped();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule